// File: doc/BRIEF.md
# Frame Pulse Format Detector

This block watches the frame synchronisation line of a TDM backplane carrying 2.048 Mb/s streams clocked by a 4.096 MHz serial clock. It decides by itself whether the frame pulse is active-low or active-high, and needs no configuration. Once it has seen two pulses of the same polarity exactly one frame apart, it declares lock. It then drives the timing that every stream slice on the chip shares: a bit-boundary strobe, an input-sample strobe, a bit index, a channel index and a frame-start strobe.

The design is single-edge synchronous. It runs on an internal clock at twice the serial rate, and receives the serial clock as a level, `sclk_in`, that must toggle on every internal cycle. A cycle in which `sclk_in` reads 0 after reading 1 on the previous cycle is a falling tick. The frame line is sampled only on falling ticks, so one frame is 512 samples.

While locked, each internal cycle is one tick of the frame. A frame has 1024 ticks: 4 per bit, 8 bits per channel, 32 channels. Within a bit, tick 0 is the boundary edge and tick 3 is the sample point. For an active-low frame pulse these are falling and rising serial edges. For an active-high frame pulse they are rising and falling serial edges.

Top module: `fpd_frame_detect`

## Requirements
- R1: While `rst_n` is low, `locked`, `fmt_high`, all three strobes, `bit_idx` and `chan_idx` are 0.
- R2: A pulse is one frame-line sample of the active level, with an idle sample before and after it, read on three consecutive falling ticks. The sequence 1,0,1 is an active-low pulse and sets `fmt_high`=0 on lock. The sequence 0,1,0 is an active-high pulse and sets `fmt_high`=1 on lock.
- R3: Two pulses of the same polarity whose active samples are exactly 512 samples apart set `locked`=1, with `fmt_high` valid. Both are visible in the clock cycle after the falling tick that reads the idle sample following the second pulse.
- R4: A pulse at any other spacing, or of the opposite polarity, clears `locked` in the cycle after its detecting tick. That pulse becomes the new reference, so a matching pulse 512 samples later locks again.
- R5: If 512 samples pass after the last pulse with no new pulse, lock is dropped and the reference is discarded. A pulse 1024 samples after the last one therefore does not lock; it only starts a new reference.
- R6: While `locked` is 0, `bit_stb`, `samp_stb` and `frame_stb` are 0, and `bit_idx` and `chan_idx` are 0.
- R7: Active-low format. Each frame has tick positions p = 0..1023, with `bit_stb`=1 at p mod 4 = 0, `samp_stb`=1 at p mod 4 = 3, `bit_idx` = (p/4) mod 8, `chan_idx` = p/32, and `frame_stb`=1 at p = 0. In the cycle after the detecting tick, p = 1.
- R8: Active-high format. The tick positions are those of R7, except that in the cycle after the detecting tick, p = 0.
- R9: While correctly spaced pulses keep arriving, lock holds. Tick position advances by one per cycle and wraps from 1023 to 0, with no jump at a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at twice the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock level, toggling every internal cycle |
| fsync_in | input | 1 | Frame synchronisation line |
| locked | output | 1 | Format detected and timing valid |
| fmt_high | output | 1 | 1 = active-high frame pulse, 0 = active-low |
| bit_stb | output | 1 | Bit-boundary tick |
| samp_stb | output | 1 | Input sample tick, three quarters into the bit |
| frame_stb | output | 1 | First tick of channel 0, bit 0 |
| bit_idx | output | 3 | Bit position within the channel |
| chan_idx | output | 5 | Channel position within the frame |

## Verification
A wrong reference or gap count shows up at `locked` within one frame of the faulty pulse. The bench sees it as a lock that comes too early, too late, or not at all in the cycle after the detecting edge. A wrong phase load or counter cascade appears at once as a mismatch on the strobes or indices, and the bench compares these every cycle over several whole frames in both formats. A fault in the timeout path takes 512 samples to show: the stale reference would lock on a pulse two frames later.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

   typedef enum logic {
      FMT_LOW_ACTIVE  = 1'b0,
      FMT_HIGH_ACTIVE = 1'b1
   } fmt_e;

   localparam int TICKS_PER_BIT = 4;
   localparam int SAMPLE_TICK   = 3;
   localparam int SCLK_PER_BIT  = 2;

endpackage

// File: rtl/fpd_edge_tap.sv
module fpd_edge_tap
   import fpd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic fsync,
   output logic fall_tick,
   output logic pulse_seen,
   output fmt_e pulse_pol
);

   logic       sclk_q;
   logic [1:0] hist_q;
   logic       low_hit;
   logic       high_hit;

   // falling serial edge seen between two internal cycles
   assign fall_tick = sclk_q & ~sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         hist_q <= '0;
      end else begin
         sclk_q <= sclk;
         if (fall_tick)
            hist_q <= {hist_q[0], fsync};
      end
   end

   // oldest, middle, newest sample: one active sample between idles
   assign low_hit    = fall_tick &  hist_q[1] & ~hist_q[0] &  fsync;
   assign high_hit   = fall_tick & ~hist_q[1] &  hist_q[0] & ~fsync;
   assign pulse_seen = low_hit | high_hit;
   assign pulse_pol  = high_hit ? FMT_HIGH_ACTIVE : FMT_LOW_ACTIVE;

endmodule

// File: rtl/fpd_lock_fsm.sv
module fpd_lock_fsm
   import fpd_pkg::*;
#(
   parameter int FRAME_SAMPLES = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fall_tick,
   input  logic pulse_seen,
   input  fmt_e pulse_pol,
   output logic locked_q,
   output logic locked_d,
   output fmt_e mode_q,
   output logic resync
);

   localparam int GW = $clog2(FRAME_SAMPLES + 1);
   localparam logic [GW-1:0] FULL = GW'(FRAME_SAMPLES);

   logic          have_q, have_n;
   fmt_e          cand_q, cand_n;
   logic [GW-1:0] gap_q, gap_n;
   fmt_e          mode_n;
   logic          match;
   logic          timeout;

   assign match   = have_q && (pulse_pol == cand_q) && (gap_q == FULL);
   assign timeout = fall_tick && have_q && !pulse_seen && (gap_q == FULL);
   assign resync  = pulse_seen && match;

   always_comb begin
      have_n   = have_q;
      cand_n   = cand_q;
      gap_n    = gap_q;
      locked_d = locked_q;
      mode_n   = mode_q;
      if (pulse_seen) begin
         have_n   = 1'b1;
         cand_n   = pulse_pol;
         gap_n    = GW'(1);
         locked_d = match;
         if (match)
            mode_n = pulse_pol;
      end else if (timeout) begin
         have_n   = 1'b0;
         gap_n    = '0;
         locked_d = 1'b0;
      end else if (fall_tick && have_q) begin
         gap_n = gap_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_q   <= 1'b0;
         cand_q   <= FMT_LOW_ACTIVE;
         gap_q    <= '0;
         locked_q <= 1'b0;
         mode_q   <= FMT_LOW_ACTIVE;
      end else begin
         have_q   <= have_n;
         cand_q   <= cand_n;
         gap_q    <= gap_n;
         locked_q <= locked_d;
         mode_q   <= mode_n;
      end
   end

   // R5: spacing counter never runs past one frame
   p_gap_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q <= FULL);

   // R3: lock only follows a confirming pulse
   p_lock_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_q) |-> $past(resync));

   // R4 / R5: lock only drops on a bad pulse or a missing one
   p_lock_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked_q) |-> ($past(pulse_seen) || $past(timeout)));

   // R9: format cannot change while lock holds
   p_mode_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_q && $past(locked_q)) |-> $stable(mode_q));

endmodule

// File: rtl/fpd_slot_timer.sv
module fpd_slot_timer
   import fpd_pkg::*;
#(
   parameter int CH_PER_FRAME = 32,
   parameter int BITS_PER_CH  = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            run,
   input  logic                            load,
   input  logic                            load_low,
   input  logic                            locked,
   output logic [$clog2(BITS_PER_CH)-1:0]  bit_idx,
   output logic [$clog2(CH_PER_FRAME)-1:0] chan_idx,
   output logic                            bit_stb,
   output logic                            samp_stb,
   output logic                            frame_stb
);

   localparam int NSTG = 3;
   localparam int PW   = $clog2(TICKS_PER_BIT);

   function automatic int stage_mod(input int g);
      case (g)
         0:       return TICKS_PER_BIT;
         1:       return BITS_PER_CH;
         default: return CH_PER_FRAME;
      endcase
   endfunction

   logic [NSTG:0]   en;
   logic [NSTG-1:0] at_max;
   logic [PW-1:0]   phase;

   assign en[0] = 1'b1;

   for (genvar g = 0; g < NSTG; g++) begin : g_stage
      localparam int MODV = stage_mod(g);
      localparam int SW   = $clog2(MODV);
      localparam logic [SW-1:0] LAST = SW'(MODV - 1);

      logic [SW-1:0] cnt_r;
      logic [SW-1:0] init_v;

      if (g == 0) begin : g_phase
         // active-low pulse: detecting cycle is tick 0, so resume at 1
         assign init_v = load_low ? SW'(1) : '0;
         assign phase  = cnt_r;
      end else if (g == 1) begin : g_bit
         assign init_v  = '0;
         assign bit_idx = cnt_r;
      end else begin : g_chan
         assign init_v   = '0;
         assign chan_idx = cnt_r;
      end

      assign at_max[g] = (cnt_r == LAST);
      assign en[g+1]   = en[g] & at_max[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_r <= '0;
         else if (!run)
            cnt_r <= '0;
         else if (load)
            cnt_r <= init_v;
         else if (en[g])
            cnt_r <= at_max[g] ? '0 : cnt_r + 1'b1;
      end
   end

   assign bit_stb   = locked && (phase == '0);
   assign samp_stb  = locked && (phase == PW'(SAMPLE_TICK));
   assign frame_stb = locked && (phase == '0) && (bit_idx == '0) && (chan_idx == '0);

   // R6: counters sit at zero whenever lock is absent
   p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> (phase == '0 && bit_idx == '0 && chan_idx == '0));

   // R7: sample point falls three ticks after a bit boundary
   p_sample_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && $past(locked, 3) && $past(bit_stb, 3)) |-> samp_stb);

endmodule

// File: rtl/fpd_frame_detect.sv
module fpd_frame_detect
   import fpd_pkg::*;
#(
   parameter int CH_PER_FRAME = 32,
   parameter int BITS_PER_CH  = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            sclk_in,
   input  logic                            fsync_in,
   output logic                            locked,
   output logic                            fmt_high,
   output logic                            bit_stb,
   output logic                            samp_stb,
   output logic                            frame_stb,
   output logic [$clog2(BITS_PER_CH)-1:0]  bit_idx,
   output logic [$clog2(CH_PER_FRAME)-1:0] chan_idx
);

   localparam int FRAME_SAMPLES = CH_PER_FRAME * BITS_PER_CH * SCLK_PER_BIT;

   if (CH_PER_FRAME < 2) begin : g_bad_ch
      $error("CH_PER_FRAME must be at least 2");
   end
   if (BITS_PER_CH < 2) begin : g_bad_bits
      $error("BITS_PER_CH must be at least 2");
   end

   logic fall_tick;
   logic pulse_seen;
   fmt_e pulse_pol;
   logic locked_q;
   logic locked_d;
   fmt_e mode_q;
   logic resync;

   fpd_edge_tap u_tap (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk       (sclk_in),
      .fsync      (fsync_in),
      .fall_tick  (fall_tick),
      .pulse_seen (pulse_seen),
      .pulse_pol  (pulse_pol)
   );

   fpd_lock_fsm #(
      .FRAME_SAMPLES (FRAME_SAMPLES)
   ) u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .fall_tick  (fall_tick),
      .pulse_seen (pulse_seen),
      .pulse_pol  (pulse_pol),
      .locked_q   (locked_q),
      .locked_d   (locked_d),
      .mode_q     (mode_q),
      .resync     (resync)
   );

   fpd_slot_timer #(
      .CH_PER_FRAME (CH_PER_FRAME),
      .BITS_PER_CH  (BITS_PER_CH)
   ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (locked_d),
      .load      (resync),
      .load_low  (pulse_pol == FMT_LOW_ACTIVE),
      .locked    (locked_q),
      .bit_idx   (bit_idx),
      .chan_idx  (chan_idx),
      .bit_stb   (bit_stb),
      .samp_stb  (samp_stb),
      .frame_stb (frame_stb)
   );

   assign locked   = locked_q;
   assign fmt_high = (mode_q == FMT_HIGH_ACTIVE);

   // R9: the tick after a frame start is still channel 0, bit 0
   p_frame_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && $past(locked) && $past(frame_stb)) |-> (chan_idx == '0 && bit_idx == '0));

endmodule

// File: tb/sim_fpd_frame_detect.sv
module sim_fpd_frame_detect;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk_in = 1'b0;
   logic       fsync_in = 1'b1;
   logic       locked, fmt_high, bit_stb, samp_stb, frame_stb;
   logic [2:0] bit_idx;
   logic [4:0] chan_idx;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int last_fall = 0;
   int ref_e = 0;
   bit ref_on = 1'b0;
   bit ref_low = 1'b1;
   bit done = 1'b0;

   logic obs_locked, obs_fmt, obs_bs, obs_ss, obs_fs;
   logic [2:0] obs_bit;
   logic [4:0] obs_chan;

   always #5 clk = ~clk;

   fpd_frame_detect u0 (
      .clk (clk), .rst_n (rst_n), .sclk_in (sclk_in), .fsync_in (fsync_in),
      .locked (locked), .fmt_high (fmt_high), .bit_stb (bit_stb),
      .samp_stb (samp_stb), .frame_stb (frame_stb),
      .bit_idx (bit_idx), .chan_idx (chan_idx)
   );

   // pol_low, pol2_low, spacing in samples, expected lock
   localparam logic [14:0] VEC [7] = '{
      {1'b1, 1'b1, 12'd512, 1'b1},
      {1'b0, 1'b0, 12'd512, 1'b1},
      {1'b1, 1'b1, 12'd511, 1'b0},
      {1'b0, 1'b0, 12'd513, 1'b0},
      {1'b1, 1'b1, 12'd256, 1'b0},
      {1'b1, 1'b0, 12'd512, 1'b0},
      {1'b0, 1'b1, 12'd512, 1'b0}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic int pack_out(input logic l, input logic b, input logic s,
                                   input logic f, input logic [2:0] bi, input logic [4:0] ci);
      return int'({l, b, s, f, bi, ci});
   endfunction

   task automatic tick(input logic sc, input logic fs);
      int d, p;
      @(negedge clk);
      obs_locked = locked; obs_fmt = fmt_high; obs_bs = bit_stb;
      obs_ss = samp_stb; obs_fs = frame_stb; obs_bit = bit_idx; obs_chan = chan_idx;
      if (ref_on && cyc >= ref_e) begin
         d = cyc - ref_e;
         p = (d + (ref_low ? 1 : 0)) % 1024;
         chk(pack_out(obs_locked, obs_bs, obs_ss, obs_fs, obs_bit, obs_chan) ==
             pack_out(1'b1, (p % 4) == 0, (p % 4) == 3, p == 0, 3'((p / 4) % 8), 5'(p / 32)),
             ref_low ? "R7/R9" : "R8/R9",
             pack_out(obs_locked, obs_bs, obs_ss, obs_fs, obs_bit, obs_chan),
             pack_out(1'b1, (p % 4) == 0, (p % 4) == 3, p == 0, 3'((p / 4) % 8), 5'(p / 32)));
      end
      sclk_in = sc;
      fsync_in = fs;
      cyc++;
      if (!sc) last_fall = cyc;
   endtask

   task automatic period(input logic fs);
      tick(1'b1, fs);
      tick(1'b0, fs);
   endtask

   task automatic idle_n(input int n, input bit low);
      for (int i = 0; i < n; i++) period(low ? 1'b1 : 1'b0);
   endtask

   task automatic pulse(input bit low);
      period(low ? 1'b0 : 1'b1);
      period(low ? 1'b1 : 1'b0);
   endtask

   task automatic do_reset(input bit low);
      ref_on = 1'b0;
      rst_n = 1'b0;
      sclk_in = 1'b0;
      fsync_in = low ? 1'b1 : 1'b0;
      repeat (3) @(negedge clk);
      chk(pack_out(locked, bit_stb, samp_stb, frame_stb, bit_idx, chan_idx) == 0,
          "R1", pack_out(locked, bit_stb, samp_stb, frame_stb, bit_idx, chan_idx), 0);
      chk(fmt_high == 1'b0, "R1", int'(fmt_high), 0);
      rst_n = 1'b1;
      cyc = 1;
      idle_n(3, low);
   endtask

   task automatic quiet_check();
      chk(pack_out(obs_locked, obs_bs, obs_ss, obs_fs, obs_bit, obs_chan) == 0, "R6",
          pack_out(obs_locked, obs_bs, obs_ss, obs_fs, obs_bit, obs_chan), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // table of pulse pairs
      for (int v = 0; v < 7; v++) begin
         bit p1, p2, ex;
         int sp;
         string tag;
         p1 = VEC[v][14]; p2 = VEC[v][13]; sp = int'(VEC[v][12:1]); ex = VEC[v][0];
         tag = ex ? "R3" : (sp > 512 ? "R5" : "R4");
         do_reset(p1);
         pulse(p1);
         idle_n(sp - 4, p1);
         idle_n(2, p2);
         pulse(p2);
         tick(1'b1, p2 ? 1'b1 : 1'b0);
         chk(obs_locked == ex, tag, int'(obs_locked), int'(ex));
         if (ex) chk(obs_fmt == !p1, "R2", int'(obs_fmt), int'(!p1));
         if (!ex) quiet_check();
         tick(1'b0, p2 ? 1'b1 : 1'b0);
      end

      // active-low timing across frames, then loss and relock
      do_reset(1'b1);
      pulse(1'b1);
      idle_n(510, 1'b1);
      pulse(1'b1);
      ref_e = last_fall; ref_low = 1'b1; ref_on = 1'b1;
      for (int k = 0; k < 2; k++) begin
         idle_n(510, 1'b1);
         pulse(1'b1);
      end
      idle_n(40, 1'b1);
      ref_on = 1'b0;
      chk(fmt_high == 1'b0, "R2", int'(fmt_high), 0);
      idle_n(512 - 2 - 40 - 212, 1'b1);
      pulse(1'b1);                      // 300 samples after the last one
      tick(1'b1, 1'b1);
      chk(obs_locked == 1'b0, "R4", int'(obs_locked), 0);
      quiet_check();
      tick(1'b0, 1'b1);
      for (int i = 0; i < 8; i++) begin
         tick(1'b1, 1'b1); quiet_check();
         tick(1'b0, 1'b1); quiet_check();
      end
      idle_n(512 - 2 - 9, 1'b1);
      pulse(1'b1);
      tick(1'b1, 1'b1);
      chk(obs_locked == 1'b1, "R4", int'(obs_locked), 1);
      tick(1'b0, 1'b1);
      idle_n(1024 - 2 - 1, 1'b1);
      pulse(1'b1);                      // two frames after the last pulse
      tick(1'b1, 1'b1);
      chk(obs_locked == 1'b0, "R5", int'(obs_locked), 0);
      quiet_check();
      tick(1'b0, 1'b1);
      idle_n(512 - 2 - 1, 1'b1);
      pulse(1'b1);
      tick(1'b1, 1'b1);
      chk(obs_locked == 1'b1, "R5", int'(obs_locked), 1);
      tick(1'b0, 1'b1);

      // active-high timing
      do_reset(1'b0);
      pulse(1'b0);
      idle_n(510, 1'b0);
      pulse(1'b0);
      ref_e = last_fall; ref_low = 1'b0; ref_on = 1'b1;
      idle_n(510, 1'b0);
      pulse(1'b0);
      idle_n(60, 1'b0);
      ref_on = 1'b0;
      chk(fmt_high == 1'b1, "R2", int'(fmt_high), 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule